// File: doc/BRIEF.md
# Late-Resolution Event Monitor

This block counts sampling events on an asynchronous input that resolve late. A capture flop samples the asynchronous data on the main clock. A second flop takes a copy of the capture output on a separate clock. That clock is the main clock delayed by a programmable phase S, so S is the time the capture flop has to settle. A third flop takes the capture output again at the next main edge, which is the end of the cycle.

The early sample lives on the delayed clock, so a retiming flop moves it back onto the main clock. It is then compared with the end-of-cycle sample. If the two disagree, the capture output changed after time S, and the registered compare flags one event for that cycle.

A run is a window in which run_en is high. Software or a controller sets a phase S, raises run_en and later drops it. It then reads the count and the completion flag, and repeats the run for the next phase value.

Top module: `late_event_monitor`

## Requirements
- R1: After reset, evt_count is 0, evt_flag is 0 and run_done is 0.
- R2: When the delayed-clock sample and the end-of-cycle sample always agree, evt_flag stays 0 and evt_count stays 0. This holds for any phase S strictly inside the main clock period and any data pattern.
- R3: A disagreement seen at main edge E (retimed sample against end-of-cycle sample) drives evt_flag high for the single cycle after edge E+1. The count rises by exactly 1 at edge E+2.
- R4: evt_count does not change while run_en is low, even when disagreements are flagged.
- R5: At the first main edge where run_en is seen high after being low, evt_count becomes 0.
- R6: The counter saturates at its all-ones value (2^CNT_W-1) and holds there for further events in the same run.
- R7: run_done becomes 1 at the first main edge where run_en is seen low after being high. It returns to 0 at the edge where a new run starts.
- R8: A disagreement on each of N consecutive main edges adds exactly N to the count, which is one per cycle, when no saturation occurs.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_main | input | 1 | Main sampling clock |
| clk_shift | input | 1 | Main clock delayed by the resolution phase S |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| din_async | input | 1 | Asynchronous data under observation |
| run_en | input | 1 | Run window, synchronous to clk_main |
| evt_flag | output | 1 | Registered one-cycle event indication |
| evt_count | output | CNT_W | Saturating event count of the current or last run |
| run_done | output | 1 | Set when a run has ended |

## Verification
Two internal faults show up directly at the ports. If the retiming flop were missing or on the wrong clock, evt_flag would rise within one cycle of a data toggle, even though no event was injected. If the counter increment or clear logic were wrong, evt_count would be off two edges after an injected disagreement, or one edge after run_en rises. A wrong saturation or run-gating state shows only at the count read when the run ends. The bench therefore reads the count after every run, for each phase value and each event total.

// File: rtl/lem_pkg.sv
`timescale 1ns/1ps
package lem_pkg;
  // pair of main-domain samples taken from the capture flop
  typedef struct packed {
    logic retimed;  // delayed-clock sample after retiming
    logic eoc;      // end-of-cycle sample
  } sample_pair_t;
endpackage

// File: rtl/lem_rst_sync.sv
`timescale 1ns/1ps
module lem_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [STAGES-1:0] chain_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain_q <= '0;
    else        chain_q <= {chain_q[STAGES-2:0], 1'b1};
  end

  assign rst_sync_n = chain_q[STAGES-1];
endmodule

// File: rtl/lem_sample_front.sv
`timescale 1ns/1ps
module lem_sample_front (
  input  logic clk_main,
  input  logic clk_shift,
  input  logic rst_n,
  input  logic din_async,
  output logic evt_o
);
  import lem_pkg::*;

  logic         cap_q;     // first sample of the asynchronous input
  logic         shift_q;   // copy taken S after the main edge
  sample_pair_t pair_q;    // retimed and end-of-cycle samples
  logic         mism_d;
  logic         mism_q;

  // capture, end-of-cycle and retiming flops on the main clock
  always_ff @(posedge clk_main or negedge rst_n) begin
    if (!rst_n) begin
      cap_q  <= 1'b0;
      pair_q <= '0;
    end else begin
      cap_q          <= din_async;
      pair_q.eoc     <= cap_q;
      pair_q.retimed <= shift_q;
    end
  end

  // phase-shifted sample of the capture output
  always_ff @(posedge clk_shift or negedge rst_n) begin
    if (!rst_n) shift_q <= 1'b0;
    else        shift_q <= cap_q;
  end

  always_comb mism_d = pair_q.retimed ^ pair_q.eoc;

  always_ff @(posedge clk_main or negedge rst_n) begin
    if (!rst_n) mism_q <= 1'b0;
    else        mism_q <= mism_d;
  end

  assign evt_o = mism_q;
endmodule

// File: rtl/lem_run_ctrl.sv
`timescale 1ns/1ps
module lem_run_ctrl (
  input  logic clk,
  input  logic rst_n,
  input  logic run_en,
  output logic run_start,
  output logic done_o
);
  logic en_q;
  logic done_q, done_d;
  logic run_stop;

  always_comb begin
    run_start = run_en & ~en_q;
    run_stop  = ~run_en & en_q;
    done_d    = done_q;
    if (run_start)     done_d = 1'b0;
    else if (run_stop) done_d = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_q   <= 1'b0;
      done_q <= 1'b0;
    end else begin
      en_q   <= run_en;
      done_q <= done_d;
    end
  end

  assign done_o = done_q;
endmodule

// File: rtl/lem_event_counter.sv
`timescale 1ns/1ps
module lem_event_counter #(
  parameter int CNT_W = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run_en,
  input  logic             run_start,
  input  logic             evt,
  output logic [CNT_W-1:0] count_o
);
  localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};
  localparam logic [CNT_W-1:0] CNT_ONE = {{(CNT_W-1){1'b0}}, 1'b1};

  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             cnt_en;

  always_comb begin
    cnt_en = run_en & evt & (cnt_q != CNT_MAX);
    cnt_d  = cnt_q;
    if (run_start)   cnt_d = '0;
    else if (cnt_en) cnt_d = cnt_q + CNT_ONE;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  assign count_o = cnt_q;
endmodule

// File: rtl/late_event_monitor.sv
`timescale 1ns/1ps
module late_event_monitor #(
  parameter int CNT_W = 32
) (
  input  logic             clk_main,
  input  logic             clk_shift,
  input  logic             rst_n,
  input  logic             din_async,
  input  logic             run_en,
  output logic             evt_flag,
  output logic [CNT_W-1:0] evt_count,
  output logic             run_done
);
  logic rst_core_n;
  logic evt_w;
  logic start_w;

  lem_rst_sync #(.STAGES(2)) u_rst (
    .clk        (clk_main),
    .rst_n      (rst_n),
    .rst_sync_n (rst_core_n)
  );

  lem_sample_front u_front (
    .clk_main  (clk_main),
    .clk_shift (clk_shift),
    .rst_n     (rst_core_n),
    .din_async (din_async),
    .evt_o     (evt_w)
  );

  lem_run_ctrl u_ctrl (
    .clk       (clk_main),
    .rst_n     (rst_core_n),
    .run_en    (run_en),
    .run_start (start_w),
    .done_o    (run_done)
  );

  lem_event_counter #(.CNT_W(CNT_W)) u_cnt (
    .clk       (clk_main),
    .rst_n     (rst_core_n),
    .run_en    (run_en),
    .run_start (start_w),
    .evt       (evt_w),
    .count_o   (evt_count)
  );

  assign evt_flag = evt_w;
endmodule

// File: rtl/late_event_monitor_chk.sv
`timescale 1ns/1ps
module late_event_monitor_chk #(
  parameter int CNT_W = 32
) (
  input logic             clk_main,
  input logic             rst_n,
  input logic             run_en,
  input logic             evt_flag,
  input logic [CNT_W-1:0] evt_count,
  input logic             run_done
);
  localparam logic [CNT_W-1:0] CMAX = {CNT_W{1'b1}};
  localparam logic [CNT_W-1:0] CONE = {{(CNT_W-1){1'b0}}, 1'b1};

  logic en_seen_q;
  always_ff @(posedge clk_main or negedge rst_n) begin
    if (!rst_n) en_seen_q <= 1'b0;
    else        en_seen_q <= run_en;
  end

  // R4: no counting outside a run
  assert_hold_idle_R4: assert property (@(posedge clk_main) disable iff (!rst_n)
    !run_en |=> $stable(evt_count));

  // R5: run start clears the count
  assert_clear_start_R5: assert property (@(posedge clk_main) disable iff (!rst_n)
    (run_en && !en_seen_q) |=> (evt_count == '0));

  // R7: completion flag follows the run window
  assert_done_set_R7: assert property (@(posedge clk_main) disable iff (!rst_n)
    (en_seen_q && !run_en) |=> run_done);
  assert_done_clr_R7: assert property (@(posedge clk_main) disable iff (!rst_n)
    run_en |=> !run_done);

  // R6: saturation holds
  assert_no_overflow_R6: assert property (@(posedge clk_main) disable iff (!rst_n)
    (evt_count == CMAX && run_en && en_seen_q) |=> (evt_count == CMAX));

  // R3 / R8: each flagged cycle in a run adds exactly one
  assert_step_one_R3: assert property (@(posedge clk_main) disable iff (!rst_n)
    (evt_flag && run_en && en_seen_q && evt_count != CMAX)
      |=> (evt_count == $past(evt_count) + CONE));

  // R2: no flag, no change inside a run
  assert_quiet_R2: assert property (@(posedge clk_main) disable iff (!rst_n)
    (!evt_flag && !(run_en && !en_seen_q)) |=> $stable(evt_count));
endmodule

bind late_event_monitor late_event_monitor_chk #(.CNT_W(CNT_W)) u_chk (
  .clk_main  (clk_main),
  .rst_n     (rst_core_n),
  .run_en    (run_en),
  .evt_flag  (evt_flag),
  .evt_count (evt_count),
  .run_done  (run_done)
);

// File: tb/sim_late_event_monitor.sv
`timescale 1ns/1ps
module sim_late_event_monitor;
  localparam int CLK_PERIOD = 10;
  localparam int CW         = 6;
  localparam int CMAX       = (1 << CW) - 1;

  logic clk_main  = 1'b0;
  logic clk_shift = 1'b0;
  logic rst_n     = 1'b0;
  logic din       = 1'b0;
  logic run_en    = 1'b0;
  logic toggle_on = 1'b0;
  int   shift_ns  = 3;
  int   total     = 0;
  int   bad       = 0;

  logic          flag;
  logic [CW-1:0] cnt;
  logic          done;

  late_event_monitor #(.CNT_W(CW)) u0 (
    .clk_main  (clk_main),
    .clk_shift (clk_shift),
    .rst_n     (rst_n),
    .din_async (din),
    .run_en    (run_en),
    .evt_flag  (flag),
    .evt_count (cnt),
    .run_done  (done)
  );

  always #(CLK_PERIOD/2) clk_main = ~clk_main;
  always @(clk_main) clk_shift <= #(shift_ns) clk_main;

  // asynchronous data source at a nearby frequency
  initial begin
    forever begin
      #7.3;
      if (toggle_on) din = ~din;
    end
  end

  task automatic chk(input string tag, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic start_run();
    @(negedge clk_main) run_en = 1'b1;
    @(negedge clk_main);
    chk("R5 count cleared at run start", int'(cnt), 0);
    chk("R7 done cleared at run start", int'(done), 0);
  endtask

  task automatic stop_run(input int exp_cnt);
    @(negedge clk_main) run_en = 1'b0;
    @(negedge clk_main);
    chk("R7 done after run end", int'(done), 1);
    chk("R2/R8 final count", int'(cnt), exp_cnt);
  endtask

  // forces the delayed-clock sample against held data across n main edges
  task automatic inject(input int n);
    if (n > 0) begin
      @(posedge clk_main);
      #(CLK_PERIOD-1);
      for (int i = 0; i < n; i++) begin
        if (din) force u0.u_front.shift_q = 1'b0;
        else     force u0.u_front.shift_q = 1'b1;
        @(posedge clk_main);
        #1 release u0.u_front.shift_q;
        if (i < n-1) #(CLK_PERIOD-2);
      end
    end
    repeat (4) @(negedge clk_main);
  endtask

  initial begin
    #(CLK_PERIOD*150000);
    total++;
    bad++;
    $display("FAIL watchdog expired");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    int highs;
    int s_tab[5] = '{2, 3, 5, 7, 8};
    repeat (3) @(negedge clk_main);
    chk("R1 count in reset", int'(cnt), 0);
    chk("R1 flag in reset", int'(flag), 0);
    chk("R1 done in reset", int'(done), 0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk_main);
    chk("R1 count after reset", int'(cnt), 0);
    chk("R1 done after reset", int'(done), 0);

    // R2: free-running data at every phase, no divergence
    for (int si = 0; si < 5; si++) begin
      shift_ns = s_tab[si];
      repeat (3) @(negedge clk_main);
      start_run();
      toggle_on = 1'b1;
      highs = 0;
      for (int c = 0; c < 300; c++) begin
        @(negedge clk_main);
        if (flag) highs++;
      end
      toggle_on = 1'b0;
      chk("R2 no flag without divergence", highs, 0);
      repeat (3) @(negedge clk_main);
      stop_run(0);
    end

    // R3: exact pipeline timing of one event
    shift_ns = 5;
    din = 1'b1;
    repeat (3) @(negedge clk_main);
    start_run();
    @(posedge clk_main);
    #(CLK_PERIOD-1) force u0.u_front.shift_q = 1'b0;
    @(posedge clk_main);
    #1 release u0.u_front.shift_q;
    @(negedge clk_main);
    chk("R3 flag low one cycle after sample", int'(flag), 0);
    @(negedge clk_main);
    chk("R3 flag high two edges after sample", int'(flag), 1);
    chk("R3 count not yet updated", int'(cnt), 0);
    @(negedge clk_main);
    chk("R3 flag single cycle", int'(flag), 0);
    chk("R3 count after one event", int'(cnt), 1);

    // R8: consecutive events
    din = 1'b0;
    repeat (3) @(negedge clk_main);
    inject(5);
    chk("R8 five consecutive events", int'(cnt), 6);
    stop_run(6);

    // R4: events outside a run are ignored
    inject(3);
    chk("R4 count frozen while idle", int'(cnt), 6);
    chk("R4 done still set while idle", int'(done), 1);

    // R5: new run clears
    start_run();

    // R6: saturation
    inject(CMAX + 7);
    chk("R6 saturated count", int'(cnt), CMAX);
    inject(2);
    chk("R6 count held at max", int'(cnt), CMAX);
    stop_run(CMAX);

    // sweep: phase x event total
    for (int si = 0; si < 5; si++) begin
      shift_ns = s_tab[si];
      for (int n = 0; n < 5; n++) begin
        din = n[0];
        repeat (3) @(negedge clk_main);
        start_run();
        inject(n);
        stop_run(n);
      end
    end

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule